// File: doc/BRIEF.md
# PCI Interrupt Pin Router

This block steers the four level-sensitive PCI interrupt pins onto a 16-line ISA interrupt level vector. Each pin has a 4-bit target field. The fields sit in three byte-wide routing registers, and software reaches those registers through a small configuration port. A pin's field names the ISA line that the pin drives. When several pins name the same line, their levels are ORed together onto that line.

The routing registers live at configuration addresses 0x55, 0x56 and 0x57. A read at one of these addresses returns the stored byte. A read at any other address returns zero, and a write to any other address is dropped. The ISA vector is registered. It follows the pin levels and the current routing one clock behind, so a downstream interrupt controller sees clean, glitch-free levels.

Top module: `pci_irq_router`

## Requirements
- R1: Pin 0 is routed to the ISA line whose number is held in bits [7:4] of the byte at address 0x55.
- R2: Pin 1 is routed by bits [3:0] of the byte at address 0x56, and pin 2 is routed by bits [7:4] of that same byte.
- R3: Pin 3 is routed by bits [7:4] of the byte at address 0x57. The low nibbles of 0x55 and 0x57 have no effect on the ISA outputs.
- R4: Each ISA line is the OR of the levels of every pin whose target field equals that line's number.
- R5: An ISA line that no asserted pin targets is driven low.
- R6: A write to 0x55, 0x56 or 0x57 stores the whole byte, and a later read at that address returns it.
- R7: A read at any address outside 0x55 to 0x57 returns 0x00. A write to such an address changes neither the stored routing bytes nor the ISA outputs.
- R8: While reset is asserted and just after it, all three routing bytes read 0x00 and the ISA vector is zero. With those reset values, every pin routes to ISA line 0.
- R9: The ISA vector is registered. A pin change shows at the output after the next clock edge. A routing write shows one edge after the edge that stores it.
- R10: Every 4-bit field value selects a valid line. Value 15 drives line 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | 4 | PCI interrupt pin levels, index 0 to 3 |
| cfg_addr_i | input | 8 | Configuration byte address |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_rdata_o | output | 8 | Configuration read data, combinational from address |
| isa_irq_o | output | 16 | Registered ISA interrupt level vector |

## Verification
Directed cases first drive each pin alone at its own target, including line 15. A wrong nibble or byte choice for any pin then shows up as a bit on the wrong line. All four pins sharing one line, and pairs sharing one line, separate a true OR from a last-writer-wins mux. Writes to only the unused low nibbles and to addresses outside the window must leave the outputs untouched. Random mixes of routing writes, stray addresses and pin levels then test combined behaviour against a model of the three bytes. Each pin change is sampled before and after one edge to pin down the register stage.

// File: rtl/pir_pkg.sv
package pir_pkg;
  localparam int NUM_PINS  = 4;
  localparam int NUM_LINES = 16;
  localparam int SEL_W     = $clog2(NUM_LINES);
  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 8;
  localparam int NUM_BYTES = 3;
  localparam logic [ADDR_W-1:0] BASE_ADDR = 8'h55;
  localparam int FLAT_W    = NUM_BYTES * DATA_W;

  // byte index in routing window holding pin p's field
  function automatic int unsigned pin_byte(int unsigned p);
    case (p)
      0:       return 0;
      1, 2:    return 1;
      default: return 2;
    endcase
  endfunction

  // bit offset of pin p's field inside its byte
  function automatic int unsigned pin_lsb(int unsigned p);
    return (p == 1) ? 0 : 4;
  endfunction
endpackage

// File: rtl/pir_cfg_regs.sv
module pir_cfg_regs
  import pir_pkg::*;
#(
  parameter int ADDR_BITS = ADDR_W,
  parameter int DATA_BITS = DATA_W,
  parameter int N_BYTES   = NUM_BYTES,
  parameter logic [ADDR_BITS-1:0] BASE = BASE_ADDR
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [ADDR_BITS-1:0]         addr_i,
  input  logic [DATA_BITS-1:0]         wdata_i,
  input  logic                         we_i,
  output logic [DATA_BITS-1:0]         rdata_o,
  output logic [N_BYTES*DATA_BITS-1:0] bytes_o
);
  localparam logic [ADDR_BITS-1:0] LAST = BASE + ADDR_BITS'(N_BYTES - 1);

  logic [N_BYTES-1:0] hit;
  logic               in_win;

  assign in_win = (addr_i >= BASE) && (addr_i <= LAST);

  for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
    logic [DATA_BITS-1:0] q;
    assign hit[b] = (addr_i == BASE + ADDR_BITS'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               q <= '0;
      else if (we_i && hit[b])   q <= wdata_i;
    end

    assign bytes_o[b*DATA_BITS +: DATA_BITS] = q;

    AST_WR_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == BASE + ADDR_BITS'(b)) |=> q == $past(wdata_i)); // R6
  end

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < N_BYTES; b++)
      if (hit[b]) rdata_o = bytes_o[b*DATA_BITS +: DATA_BITS];
  end

  AST_MISS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i || !in_win) |=> $stable(bytes_o)); // R7
  AST_MISS_RDZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_win |-> rdata_o == '0); // R7
endmodule

// File: rtl/pir_route_matrix.sv
module pir_route_matrix
  import pir_pkg::*;
#(
  parameter int N_PINS  = NUM_PINS,
  parameter int N_LINES = NUM_LINES,
  parameter int FLAT    = FLAT_W
) (
  input  logic [FLAT-1:0]    cfg_i,
  input  logic [N_PINS-1:0]  pin_i,
  output logic [N_LINES-1:0] line_o
);
  localparam int SW = $clog2(N_LINES);

  logic [N_PINS-1:0][SW-1:0]      sel;
  logic [N_LINES-1:0][N_PINS-1:0] hit;

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    localparam int unsigned OFS = pin_byte(p) * DATA_W + pin_lsb(p);
    assign sel[p] = cfg_i[OFS +: SW];
  end

  // wired-OR of every pin aimed at a line
  for (genvar l = 0; l < N_LINES; l++) begin : g_line
    for (genvar p = 0; p < N_PINS; p++) begin : g_tap
      assign hit[l][p] = pin_i[p] && (sel[p] == SW'(l));
    end
    assign line_o[l] = |hit[l];
  end
endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router
  import pir_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_PINS-1:0]  pin_i,
  input  logic [ADDR_W-1:0]    cfg_addr_i,
  input  logic [DATA_W-1:0]    cfg_wdata_i,
  input  logic                 cfg_we_i,
  output logic [DATA_W-1:0]    cfg_rdata_o,
  output logic [NUM_LINES-1:0] isa_irq_o
);
  logic [FLAT_W-1:0]    cfg_bytes;
  logic [NUM_LINES-1:0] line_d;
  logic [NUM_LINES-1:0] isa_q;
  logic                 live_q;

  pir_cfg_regs #(
    .ADDR_BITS(ADDR_W), .DATA_BITS(DATA_W), .N_BYTES(NUM_BYTES), .BASE(BASE_ADDR)
  ) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .we_i    (cfg_we_i),
    .rdata_o (cfg_rdata_o),
    .bytes_o (cfg_bytes)
  );

  pir_route_matrix #(
    .N_PINS(NUM_PINS), .N_LINES(NUM_LINES), .FLAT(FLAT_W)
  ) u_matrix (
    .cfg_i  (cfg_bytes),
    .pin_i  (pin_i),
    .line_o (line_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isa_q  <= '0;
      live_q <= 1'b0;
    end else begin
      isa_q  <= line_d;
      live_q <= 1'b1;
    end
  end

  assign isa_irq_o = isa_q;

  AST_QUIET_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && $past(pin_i) == '0) |-> isa_irq_o == '0); // R5
  AST_LINE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q |-> $countones(isa_irq_o) <= $countones($past(pin_i))); // R4
  AST_ANY_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && $past(pin_i) != '0) |-> isa_irq_o != '0); // R10
  AST_SINGLE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && $countones($past(pin_i)) == 1) |-> $countones(isa_irq_o) == 1); // R9
endmodule

// File: tb/pci_irq_router_test.sv
`timescale 1ns/1ps
module pci_irq_router_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  pin_i = '0;
  logic [7:0]  cfg_addr_i = '0;
  logic [7:0]  cfg_wdata_i = '0;
  logic        cfg_we_i = 1'b0;
  logic [7:0]  cfg_rdata_o;
  logic [15:0] isa_irq_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] m55 = 8'h00, m56 = 8'h00, m57 = 8'h00;

  always #2 clk_i = ~clk_i;

  pci_irq_router uut (.*);

  function automatic logic [15:0] exp_isa(logic [3:0] p, logic [7:0] a, logic [7:0] b, logic [7:0] c);
    logic [15:0] v = '0;
    if (p[0]) v[a[7:4]] = 1'b1;
    if (p[1]) v[b[3:0]] = 1'b1;
    if (p[2]) v[b[7:4]] = 1'b1;
    if (p[3]) v[c[7:4]] = 1'b1;
    return v;
  endfunction

  function automatic logic [7:0] exp_rd(logic [7:0] ad);
    case (ad)
      8'h55:   return m55;
      8'h56:   return m56;
      8'h57:   return m57;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] ad, logic [7:0] d);
    @(negedge clk_i);
    cfg_addr_i = ad; cfg_wdata_i = d; cfg_we_i = 1'b1;
    @(posedge clk_i); #1;
    cfg_we_i = 1'b0;
    case (ad)
      8'h55: m55 = d;
      8'h56: m56 = d;
      8'h57: m57 = d;
      default: ;
    endcase
  endtask

  task automatic set_pins(logic [3:0] p);
    @(negedge clk_i);
    pin_i = p;
  endtask

  task automatic settle_chk(string req);
    @(posedge clk_i); #1;
    @(posedge clk_i); #1;
    chk(req, 32'(isa_irq_o), 32'(exp_isa(pin_i, m55, m56, m57)));
  endtask

  task automatic rd_chk(string req, logic [7:0] ad);
    @(negedge clk_i);
    cfg_addr_i = ad;
    #1;
    chk(req, 32'(cfg_rdata_o), 32'(exp_rd(ad)));
  endtask

  initial begin
    #20000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    pin_i = 4'hF;
    repeat (3) @(posedge clk_i);
    #1;
    chk("R8 reset output", 32'(isa_irq_o), 32'h0);
    @(negedge clk_i); rst_ni = 1'b1;
    pin_i = 4'h0;
    rd_chk("R8 reset 0x55", 8'h55);
    rd_chk("R8 reset 0x56", 8'h56);
    rd_chk("R8 reset 0x57", 8'h57);
    set_pins(4'hF);
    settle_chk("R8 all pins on line 0");

    // R9 latency: old value before edge, new after one edge
    set_pins(4'h0);
    @(posedge clk_i); #1;
    @(negedge clk_i); pin_i = 4'h1;
    #1; chk("R9 before edge", 32'(isa_irq_o), 32'h0);
    @(posedge clk_i); #1;
    chk("R9 after one edge", 32'(isa_irq_o), 32'h1);
    wr(8'h55, 8'h30);
    chk("R9 write edge no change yet", 32'(isa_irq_o), 32'h1);
    @(posedge clk_i); #1;
    chk("R9 routing after write", 32'(isa_irq_o), 32'h8);

    wr(8'h55, 8'hA0); wr(8'h56, 8'h5C); wr(8'h57, 8'hF0);
    set_pins(4'h1); settle_chk("R1 pin0 via 0x55 hi nibble");
    set_pins(4'h2); settle_chk("R2 pin1 via 0x56 lo nibble");
    set_pins(4'h4); settle_chk("R2 pin2 via 0x56 hi nibble");
    set_pins(4'h8); settle_chk("R10 pin3 to line 15");
    chk("R10 line 15 value", 32'(isa_irq_o), 32'h8000);
    wr(8'h57, 8'hFA); wr(8'h55, 8'hA7);
    set_pins(4'h9); settle_chk("R3 low nibbles ignored");
    rd_chk("R6 readback 0x57", 8'h57);
    rd_chk("R6 readback 0x55", 8'h55);

    wr(8'h55, 8'h90); wr(8'h56, 8'h99); wr(8'h57, 8'h90);
    set_pins(4'hF); settle_chk("R4 all share line 9");
    set_pins(4'h6); settle_chk("R4 two share line 9");
    set_pins(4'h0); settle_chk("R5 no pins all low");

    wr(8'h54, 8'hFF); wr(8'h58, 8'hFF); wr(8'h00, 8'h12);
    set_pins(4'hF); settle_chk("R7 stray writes no effect");
    rd_chk("R7 read 0x54", 8'h54);
    rd_chk("R7 read 0x58", 8'h58);
    rd_chk("R7 window intact", 8'h56);

    for (int i = 0; i < 300; i++) begin
      int unsigned k = $urandom_range(0, 3);
      logic [7:0] ad;
      if (k == 0) ad = 8'($urandom);
      else ad = 8'h54 + 8'(k);
      if ($urandom_range(0, 1) == 1) wr(ad, 8'($urandom));
      set_pins(4'($urandom));
      settle_chk("R4 random routing");
      rd_chk("R6 random read", ad);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule